// File: doc/BRIEF.md
# LDPC Frame Mode Decoder and Sequencer

This block sits in front of an LDPC decoder core. It reads a 12-bit control word that comes with the first beat of each frame and splits it into the frame parameters: base graph, code rate, lifting size, number of parity-check rows and columns, and the two option flags. From these it computes how many input beats the frame will take and how many output beats it will produce. The downstream input and output stages count against these figures.

Some control words are illegal: a lifting-size index above 50, or a rate code that the selected graph does not define. For such a word the block raises a one-cycle error pulse and drops the frame, so the stages receive no parameters for it. Each accepted control word is stored in a small queue. The word at the head of that queue is presented to the output side and stays there until the output stage pops it, so the word that leaves with a decoded frame is the word that arrived with it.

Top module: `ldpc_mode_seq`

## Requirements
- R1: Bit 11 of the control word selects the graph (0 = graph 1, 1 = graph 2) and bits 10:8 select the rate code. For graph 1, rate codes 1..7 give (rows, columns) of (46,68), (35,57), (24,46), (13,35), (10,32), (7,29) and (5,27).
- R2: For graph 2, rate codes 0..4 give (rows, columns) of (42,52), (22,32), (17,27), (12,22) and (7,17).
- R3: Bits 5:0 index the lifting size. Index 0 is Z=2. The step between sizes is 1 up to 16, 2 up to 32, 4 up to 64, 8 up to 128, 16 up to 256 and 32 up to 384. Index 50 is 384.
- R4: Bit 7 set turns on reduced-syndrome mode. Bit 6 set turns off early termination, so `cfg_et_en` is the inverse of bit 6.
- R5: The input beat count is (columns - 2) * ceil(Z/64).
- R6: The output beat count is 22 for graph 1 and 10 for graph 2.
- R7: A lifting-size index of 51..63, graph 1 with rate code 0, or graph 2 with rate code 5..7 gives a one-cycle `cfg_err` pulse and no `cfg_valid`. Such a frame is not queued for the output side.
- R8: The control word is sampled only on an accepted start-of-frame beat. The parameter outputs appear one cycle later with a one-cycle `cfg_valid` pulse. Without such a beat, `cfg_valid` and `cfg_err` stay low and the parameter fields hold their values.
- R9: Accepted legal words come out on `out_mode` in arrival order. `out_valid` is high while the queue holds a word, and `out_pop` removes the head.
- R10: `in_ready` is low while the queue is full (4 words by default). A start-of-frame beat during that time is ignored.
- R11: After reset, `in_ready` is 1 and `cfg_valid`, `cfg_err` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sof | input | 1 | First beat of an input frame |
| in_mode | input | 12 | Control word carried with the first beat |
| in_ready | output | 1 | Queue has room for another word |
| cfg_valid | output | 1 | One-cycle pulse: fresh legal parameters |
| cfg_err | output | 1 | One-cycle pulse: illegal word, frame dropped |
| cfg_bg | output | 1 | Graph select (0 = graph 1) |
| cfg_rate | output | 3 | Rate code |
| cfg_z | output | 9 | Lifting size |
| cfg_mb | output | 6 | Parity-check rows |
| cfg_nb | output | 7 | Parity-check columns |
| cfg_et_en | output | 1 | Early termination enabled |
| cfg_rs_en | output | 1 | Reduced-syndrome mode enabled |
| cfg_in_beats | output | 10 | Expected input beats |
| cfg_out_beats | output | 5 | Expected output beats |
| out_pop | input | 1 | Output stage takes the head word |
| out_valid | output | 1 | A queued word is available |
| out_mode | output | 12 | Head word, echoed with the output frame |

## Verification
Every rate code of both graphs is decoded at the largest lifting size, which separates the row and column tables. A sweep over all 51 size indices at one graph checks each segment boundary of the size progression. Sizes 64 and 72 fall on either side of a 64-lane boundary, so they tell a correct ceiling from a floor in the beat count. Illegal words from all three error classes are sent between legal ones, and the echoed order then shows whether a dropped frame left anything in the queue. A burst that fills the queue, followed by one extra start beat, shows whether the full queue refuses further frames. Control-word changes without a start beat show that the block samples only on start beats.

// File: rtl/ldpc_mode_pkg.sv
package ldpc_mode_pkg;

    localparam int MODE_W    = 12;
    localparam int Z_W       = 9;
    localparam int MB_W      = 6;
    localparam int NB_W      = 7;
    localparam int OB_W      = 5;
    localparam int Z_IDX_MAX = 50;
    localparam int KB_G1     = 22;   // systematic columns, graph 1
    localparam int KB_G2     = 10;   // systematic columns, graph 2

    typedef struct packed {
        logic            bg;
        logic [2:0]      rate;
        logic [Z_W-1:0]  z;
        logic [MB_W-1:0] mb;
        logic [NB_W-1:0] nb;
        logic            et_en;
        logic            rs_en;
    } mode_cfg_t;

    // Piecewise progression of lifting sizes, one linear segment per step size
    function automatic logic [Z_W-1:0] lift_size(input logic [5:0] idx);
        logic [Z_W-1:0] k;
        k = Z_W'(idx);
        if (k < 9'd15)      lift_size = k + 9'd2;
        else if (k < 9'd23) lift_size = 9'd18  + ((k - 9'd15) << 1);
        else if (k < 9'd31) lift_size = 9'd36  + ((k - 9'd23) << 2);
        else if (k < 9'd39) lift_size = 9'd72  + ((k - 9'd31) << 3);
        else if (k < 9'd47) lift_size = 9'd144 + ((k - 9'd39) << 4);
        else                lift_size = 9'd288 + ((k - 9'd47) << 5);
    endfunction

    // Parity-check rows; zero marks an undefined graph/rate pair
    function automatic logic [MB_W-1:0] check_rows(input logic bg, input logic [2:0] rate);
        case ({bg, rate})
            4'b0_001: check_rows = 6'd46;
            4'b0_010: check_rows = 6'd35;
            4'b0_011: check_rows = 6'd24;
            4'b0_100: check_rows = 6'd13;
            4'b0_101: check_rows = 6'd10;
            4'b0_110: check_rows = 6'd7;
            4'b0_111: check_rows = 6'd5;
            4'b1_000: check_rows = 6'd42;
            4'b1_001: check_rows = 6'd22;
            4'b1_010: check_rows = 6'd17;
            4'b1_011: check_rows = 6'd12;
            4'b1_100: check_rows = 6'd7;
            default:  check_rows = 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/ldpc_mode_decode.sv
module ldpc_mode_decode
    import ldpc_mode_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_cfg_t         cfg,
    output logic              legal
);
    logic z_ok;

    always_comb begin
        cfg.bg    = mode[11];
        cfg.rate  = mode[10:8];
        cfg.rs_en = mode[7];
        cfg.et_en = ~mode[6];
        cfg.z     = lift_size(mode[5:0]);
        cfg.mb    = check_rows(mode[11], mode[10:8]);
        // columns = rows + systematic columns of the selected graph
        cfg.nb    = NB_W'(cfg.mb) + (mode[11] ? NB_W'(KB_G2) : NB_W'(KB_G1));
        z_ok      = (mode[5:0] <= 6'(Z_IDX_MAX));
        legal     = z_ok && (cfg.mb != '0);
    end
endmodule

// File: rtl/ldpc_beat_calc.sv
module ldpc_beat_calc
    import ldpc_mode_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IB_W  = 10
) (
    input  mode_cfg_t         cfg,
    output logic [IB_W-1:0]   in_beats,
    output logic [OB_W-1:0]   out_beats
);
    logic [IB_W-1:0] cols;
    logic [IB_W-1:0] zx;
    logic [IB_W-1:0] blks;

    always_comb begin
        cols      = IB_W'(cfg.nb) - IB_W'(2);
        zx        = IB_W'(cfg.z);
        blks      = (zx + IB_W'(LANES - 1)) / IB_W'(LANES);
        in_beats  = cols * blks;
        out_beats = cfg.bg ? OB_W'(KB_G2) : OB_W'(KB_G1);
    end
endmodule

// File: rtl/ldpc_mode_fifo.sv
module ldpc_mode_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/ldpc_mode_seq.sv
module ldpc_mode_seq
    import ldpc_mode_pkg::*;
#(
    parameter int LANES      = 64,
    parameter int FIFO_DEPTH = 4,
    parameter int IB_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_sof,
    input  logic [11:0]       in_mode,
    output logic              in_ready,
    output logic              cfg_valid,
    output logic              cfg_err,
    output logic              cfg_bg,
    output logic [2:0]        cfg_rate,
    output logic [8:0]        cfg_z,
    output logic [5:0]        cfg_mb,
    output logic [6:0]        cfg_nb,
    output logic              cfg_et_en,
    output logic              cfg_rs_en,
    output logic [IB_W-1:0]   cfg_in_beats,
    output logic [4:0]        cfg_out_beats,
    input  logic              out_pop,
    output logic              out_valid,
    output logic [11:0]       out_mode
);
    mode_cfg_t       dec_cfg, cfg_q;
    logic            dec_legal;
    logic [IB_W-1:0] calc_in;
    logic [OB_W-1:0] calc_out;
    logic            accept, fifo_empty, fifo_full;
    logic            valid_q, err_q;
    logic [IB_W-1:0] in_beats_q;
    logic [OB_W-1:0] out_beats_q;

    ldpc_mode_decode u_dec (
        .mode  (in_mode),
        .cfg   (dec_cfg),
        .legal (dec_legal)
    );

    ldpc_beat_calc #(.LANES(LANES), .IB_W(IB_W)) u_beats (
        .cfg       (dec_cfg),
        .in_beats  (calc_in),
        .out_beats (calc_out)
    );

    assign in_ready = !fifo_full;
    assign accept   = in_sof && in_ready;

    ldpc_mode_fifo #(.W(MODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (accept && dec_legal),
        .wdata (in_mode),
        .pop   (out_pop),
        .head  (out_mode),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q     <= 1'b0;
            err_q       <= 1'b0;
            cfg_q       <= '0;
            in_beats_q  <= '0;
            out_beats_q <= '0;
        end else begin
            valid_q <= accept && dec_legal;
            err_q   <= accept && !dec_legal;
            if (accept && dec_legal) begin
                cfg_q       <= dec_cfg;
                in_beats_q  <= calc_in;
                out_beats_q <= calc_out;
            end
        end
    end

    assign cfg_valid     = valid_q;
    assign cfg_err       = err_q;
    assign cfg_bg        = cfg_q.bg;
    assign cfg_rate      = cfg_q.rate;
    assign cfg_z         = cfg_q.z;
    assign cfg_mb        = cfg_q.mb;
    assign cfg_nb        = cfg_q.nb;
    assign cfg_et_en     = cfg_q.et_en;
    assign cfg_rs_en     = cfg_q.rs_en;
    assign cfg_in_beats  = in_beats_q;
    assign cfg_out_beats = out_beats_q;
    assign out_valid     = !fifo_empty;
endmodule

// File: rtl/ldpc_mode_seq_chk.sv
module ldpc_mode_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_sof,
    input logic        in_ready,
    input logic        cfg_valid,
    input logic        cfg_err,
    input logic        cfg_bg,
    input logic [8:0]  cfg_z,
    input logic [6:0]  cfg_nb,
    input logic [4:0]  cfg_out_beats,
    input logic        out_pop,
    input logic        out_valid,
    input logic [11:0] out_mode
);
    // R7
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_valid && cfg_err));

    // R8
    no_sof_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_sof && in_ready) |=> !cfg_valid && !cfg_err);

    // R8
    no_sof_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_sof && in_ready) |=> $stable(cfg_z) && $stable(cfg_nb));

    // R6
    out_beats_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> cfg_out_beats == (cfg_bg ? 5'd10 : 5'd22));

    // R3
    z_range_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> (cfg_z >= 9'd2) && (cfg_z <= 9'd384));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_pop |=> out_valid && $stable(out_mode));

    // R10
    full_implies_data_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);
endmodule

bind ldpc_mode_seq ldpc_mode_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_sof        (in_sof),
    .in_ready      (in_ready),
    .cfg_valid     (cfg_valid),
    .cfg_err       (cfg_err),
    .cfg_bg        (cfg_bg),
    .cfg_z         (cfg_z),
    .cfg_nb        (cfg_nb),
    .cfg_out_beats (cfg_out_beats),
    .out_pop       (out_pop),
    .out_valid     (out_valid),
    .out_mode      (out_mode)
);

// File: tb/sim_ldpc_mode_seq.sv
module sim_ldpc_mode_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_sof;
    logic [11:0] in_mode;
    logic        in_ready;
    logic        cfg_valid, cfg_err, cfg_bg, cfg_et_en, cfg_rs_en;
    logic [2:0]  cfg_rate;
    logic [8:0]  cfg_z;
    logic [5:0]  cfg_mb;
    logic [6:0]  cfg_nb;
    logic [9:0]  cfg_in_beats;
    logic [4:0]  cfg_out_beats;
    logic        out_pop;
    logic        out_valid;
    logic [11:0] out_mode;

    int n_chk = 0;
    int n_err = 0;
    bit pop_en = 1'b0;
    logic [12:0] exp_q [$];   // {err, mode}
    logic [11:0] echo_q [$];

    always #10 clk = ~clk;    // 50 MHz

    ldpc_mode_seq u0 (
        .clk(clk), .rst(rst), .in_sof(in_sof), .in_mode(in_mode), .in_ready(in_ready),
        .cfg_valid(cfg_valid), .cfg_err(cfg_err), .cfg_bg(cfg_bg), .cfg_rate(cfg_rate),
        .cfg_z(cfg_z), .cfg_mb(cfg_mb), .cfg_nb(cfg_nb), .cfg_et_en(cfg_et_en),
        .cfg_rs_en(cfg_rs_en), .cfg_in_beats(cfg_in_beats), .cfg_out_beats(cfg_out_beats),
        .out_pop(out_pop), .out_valid(out_valid), .out_mode(out_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_z(input int idx);
        int z = 2;
        for (int i = 0; i < idx; i++) begin
            if (z < 16) z += 1;
            else if (z < 32) z += 2;
            else if (z < 64) z += 4;
            else if (z < 128) z += 8;
            else if (z < 256) z += 16;
            else z += 32;
        end
        return z;
    endfunction

    function automatic int exp_mb(input int bg, input int rate);
        int g1 [8] = '{0, 46, 35, 24, 13, 10, 7, 5};
        int g2 [8] = '{42, 22, 17, 12, 7, 0, 0, 0};
        return bg ? g2[rate] : g1[rate];
    endfunction

    function automatic int exp_nb(input int bg, input int rate);
        int g1 [8] = '{0, 68, 57, 46, 35, 32, 29, 27};
        int g2 [8] = '{52, 32, 27, 22, 17, 0, 0, 0};
        return bg ? g2[rate] : g1[rate];
    endfunction

    function automatic bit is_legal(input logic [11:0] m);
        return (int'(m[5:0]) <= 50) && (exp_mb(m[11], m[10:8]) != 0);
    endfunction

    // Driver: one start beat, expectations pushed only when the beat is accepted
    task automatic send(input logic [11:0] m);
        @(negedge clk);
        in_mode = m;
        in_sof  = 1'b1;
        if (in_ready) begin
            exp_q.push_back({!is_legal(m), m});
            if (is_legal(m)) echo_q.push_back(m);
        end
        @(posedge clk);
        #2 in_sof = 1'b0;
    endtask

    // Monitor for decoded parameters
    always @(negedge clk) begin
        if (!rst && (cfg_valid || cfg_err)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected cfg pulse", 1, 0);
            end else begin
                logic [12:0] it;
                int bg, rt, zz, nb;
                it = exp_q.pop_front();
                bg = it[11]; rt = it[10:8]; zz = exp_z(it[5:0]);
                chk(cfg_err == it[12], "R7 error flag", cfg_err, it[12]);
                chk(cfg_valid == !it[12], "R7 valid flag", cfg_valid, !it[12]);
                if (!it[12]) begin
                    nb = exp_nb(bg, rt);
                    chk(cfg_bg == bg && cfg_rate == rt, "R1 graph/rate", {cfg_bg, cfg_rate}, it[11:8]);
                    chk(cfg_mb == exp_mb(bg, rt), bg ? "R2 rows" : "R1 rows", cfg_mb, exp_mb(bg, rt));
                    chk(cfg_nb == nb, bg ? "R2 cols" : "R1 cols", cfg_nb, nb);
                    chk(cfg_z == zz, "R3 lift size", cfg_z, zz);
                    chk(cfg_rs_en == it[7] && cfg_et_en == !it[6], "R4 options",
                        {cfg_rs_en, cfg_et_en}, {it[7], !it[6]});
                    chk(cfg_in_beats == (nb - 2) * ((zz + 63) / 64), "R5 in beats",
                        cfg_in_beats, (nb - 2) * ((zz + 63) / 64));
                    chk(cfg_out_beats == (bg ? 10 : 22), "R6 out beats", cfg_out_beats, bg ? 10 : 22);
                end
            end
        end
    end

    // Monitor for the echoed word
    always @(negedge clk) begin
        out_pop = 1'b0;
        if (!rst && pop_en && out_valid) begin
            if (echo_q.size() == 0) begin
                chk(1'b0, "R9 extra echoed word", out_mode, 0);
            end else begin
                logic [11:0] e;
                e = echo_q.pop_front();
                chk(out_mode == e, "R9 echo order", out_mode, e);
            end
            out_pop = 1'b1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [8:0] z_hold;
        logic [6:0] nb_hold;
        rst = 1'b1; in_sof = 1'b0; in_mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11 ready after reset", in_ready, 1);
        chk(cfg_valid == 1'b0 && cfg_err == 1'b0, "R11 pulses low", {cfg_valid, cfg_err}, 0);
        chk(out_valid == 1'b0, "R11 queue empty", out_valid, 0);

        pop_en = 1'b1;
        send(12'h732);   // graph 1, rate 7, Z=384: 150 beats
        send(12'hB2B);   // graph 2, rate 3, Z=208: 80 beats
        send(12'h8C0);   // graph 2, rate 0, Z=2, both option bits
        send(12'h11E);   // Z=64, one block per column
        send(12'h41F);   // Z=72, two blocks per column
        for (int r = 1; r < 8; r++) send({1'b0, 3'(r), 2'b10, 6'd50});   // R1 sweep
        for (int r = 0; r < 5; r++) send({1'b1, 3'(r), 2'b01, 6'd17});   // R2 sweep
        for (int i = 0; i < 51; i++) send({1'b1, 3'd4, 2'b00, 6'(i)});   // R3 sweep

        // R7 illegal words among legal ones
        send(12'h032);
        send(12'h310);
        send(12'hD05);
        send(12'h133);
        send(12'hF3F);
        send(12'h205);
        repeat (4) @(negedge clk);

        // R8: word changes without a start beat
        z_hold = cfg_z; nb_hold = cfg_nb;
        in_mode = 12'hFFF;
        repeat (3) @(negedge clk);
        in_mode = 12'h000;
        repeat (2) @(negedge clk);
        chk(cfg_z == z_hold && cfg_nb == nb_hold, "R8 fields held", cfg_z, z_hold);

        // R10: fill the queue, then one extra start beat
        pop_en = 1'b0;
        repeat (3) @(negedge clk);
        send(12'h301);
        send(12'h402);
        send(12'h903);
        send(12'h5C4);
        @(negedge clk);
        chk(in_ready == 1'b0, "R10 ready low when full", in_ready, 0);
        send(12'h100);   // must be ignored
        repeat (3) @(negedge clk);
        chk(out_mode == 12'h301, "R10 head unchanged while full", out_mode, 12'h301);
        pop_en = 1'b1;
        repeat (12) @(negedge clk);

        chk(exp_q.size() == 0, "R8 all parameters seen", exp_q.size(), 0);
        chk(echo_q.size() == 0, "R9 all words echoed", echo_q.size(), 0);
        chk(out_valid == 1'b0, "R10 ignored frame not queued", out_valid, 0);
        chk(in_ready == 1'b1, "R10 ready after drain", in_ready, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule